// File: doc/BRIEF.md
# Powerdown Entry and Wakeup Controller

This block decides when the CPU and peripheral clocks of a small microcontroller core may run. When the CPU asks for powerdown and the low-power modes are enabled, the block turns off the oscillator and PLL enables. It holds both internal clock enables low, forces the clock-output pin high and parks the bus-control outputs in their inactive state. It brings the core back to run mode when the reset pin is pulled low, when an internal reset fires, or when the external interrupt line is seen high.

On an interrupt wakeup the oscillator comes back first. The internal clocks stay off while a loadable down-counter runs out, and that counter stands in for the external timing capacitor. The wakeup always latches an interrupt pending flag, whether or not the interrupt is enabled. A service request follows only if the interrupt is enabled. The block also drives a reset-pin pulldown pulse of fixed length on every reset event. When the PLL is the selected clock source, it keeps the clocks off for a minimum number of cycles after a reset begins.

The low-power enable comes from a configuration bit. The block copies that bit only while it is in its reset state. All inputs except the power-on reset are synchronous to `clk`, which is a free-running reference clock. The power-on reset `sys_rst_n` is asynchronous and is released synchronously inside the block.

Top module: `pwrdn_ctrl`

## Requirements
- R1: The low-power enable is copied from `cfg_pd` only while the block is in its reset state. A change of `cfg_pd` while running has no effect on a later `pd_req`.
- R2: With the low-power enable at 0, a `pd_req` pulse is ignored: `cpu_clk_en` and `osc_en` stay 1.
- R3: One cycle after `pd_req` is sampled with the enable at 1, the block is in powerdown: `osc_en`=0, `pll_en`=0, `cpu_clk_en`=0, `per_clk_en`=0, `clkout_hi`=1 and `bus_idle`=1.
- R4: In powerdown, `extint` sampled high for a single cycle wakes the block. On the next cycle `osc_en`=1 and `ext_pend`=1, whatever the value of `int_en`.
- R5: After the wakeup edge, `cpu_clk_en` stays 0 for exactly `wake_dly`+1 cycles and then becomes 1. The oscillator is enabled throughout that time.
- R6: With `int_en`=0, `ext_pend` stays 1 and `int_req` stays 0 in run mode until `pend_clr` is pulsed. With `int_en`=1, `int_req`=1 in run mode until `int_ack` clears the flag.
- R7: A reset event (`rst_pin_n` low or `int_rst` high) takes priority over a wakeup in the same cycle. On the next cycle the block is in reset: clocks are off, `clkout_hi`=0 and `ext_pend`=0.
- R8: A falling edge on `rst_pin_n`, or an `int_rst` pulse, drives `rst_pulldown` high for exactly PULLDN_STATES (16) cycles, starting on the cycle after the event.
- R9: With `pll_sel`=1, a reset keeps `cpu_clk_en` at 0 for exactly RST_HOLD_CYC+1 cycles (41 by default), even when the pin is low for a shorter time.
- R10: With `pll_sel`=0, a reset pin held low for L cycles keeps `cpu_clk_en` at 0 for exactly L cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference and wake-detect clock |
| sys_rst_n | input | 1 | Asynchronous active-low power-on reset |
| rst_pin_n | input | 1 | Reset pin level, active low, sampled on clk |
| int_rst | input | 1 | Internal reset request pulse |
| pll_sel | input | 1 | 1 when the PLL or an external clock is the source |
| cfg_pd | input | 1 | Configuration bit enabling the low-power modes |
| pd_req | input | 1 | Powerdown request from the CPU |
| extint | input | 1 | External interrupt line, level-sensitive in powerdown |
| int_en | input | 1 | Interrupt enable (mask) for the external interrupt |
| pend_clr | input | 1 | Software clear of the pending flag |
| int_ack | input | 1 | Interrupt serviced, clears the pending flag |
| wake_dly | input | WAKE_W | Stabilisation delay in cycles minus one |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | PLL enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| clkout_hi | output | 1 | Forces the clock-output pin high |
| bus_idle | output | 1 | Holds the bus-control outputs inactive |
| ext_pend | output | 1 | External interrupt pending flag |
| int_req | output | 1 | Service request for the external interrupt |
| rst_pulldown | output | 1 | Reset-pin pulldown drive |

## Verification
A wrong power state is visible at the clock-enable outputs on the cycle after the deciding edge. A missed powerdown keeps `osc_en` high, a missed wakeup keeps it low, and a lost reset priority shows `clkout_hi` high where it should be low. Errors in the delay counters show up only as a wrong count of gated cycles, so the bench counts every gated cycle and every pulldown cycle, and an off-by-one fails once the window closes. A wrong pending flag or enable copy shows up later, as a service request in the wrong state or a powerdown that fails to happen.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;
  typedef enum logic [1:0] {
    PS_RESET = 2'd0,
    PS_RUN   = 2'd1,
    PS_SLEEP = 2'd2,
    PS_WAKE  = 2'd3
  } pstate_e;
endpackage

// File: rtl/pwrdn_dncount.sv
// Loadable down-counter that stops at zero.
module pwrdn_dncount #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec_en,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_d;

  assign zero = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (dec_en && !zero)
      cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pwrdn_rst_ctl.sv
// Reset event detection, pulldown pulse and reset-hold timer.
module pwrdn_rst_ctl #(
  parameter int PULLDN_STATES = 16,
  parameter int RST_HOLD_CYC  = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_pin_n,
  input  logic int_rst,
  input  logic in_reset,
  output logic rst_req,
  output logic hold_done,
  output logic rst_pulldown
);
  localparam int PD_W   = $clog2(PULLDN_STATES + 1);
  localparam int HOLD_W = $clog2(RST_HOLD_CYC + 1);

  logic              pin_q;
  logic              pin_fall;
  logic              pd_load;
  logic              pd_zero;
  logic [HOLD_W-1:0] hold_q, hold_d;

  assign rst_req  = !rst_pin_n || int_rst;
  assign pin_fall = pin_q && !rst_pin_n;
  assign pd_load  = pin_fall || int_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b1;
    else        pin_q <= rst_pin_n;
  end

  pwrdn_dncount #(.W(PD_W)) u_pulldown_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (pd_load),
    .load_val (PD_W'(PULLDN_STATES)),
    .dec_en   (1'b1),
    .zero     (pd_zero)
  );

  assign rst_pulldown = !pd_zero;

  assign hold_done = (hold_q == HOLD_W'(RST_HOLD_CYC));

  always_comb begin
    hold_d = hold_q;
    if (!in_reset)
      hold_d = '0;
    else if (!hold_done)
      hold_d = hold_q + HOLD_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end
endmodule

// File: rtl/pwrdn_fsm.sv
// Power state sequencing, enable copy and pending flag.
module pwrdn_fsm
  import pwrdn_pkg::*;
#(
  parameter int WAKE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_req,
  input  logic              hold_done,
  input  logic              pll_sel,
  input  logic              cfg_pd,
  input  logic              pd_req,
  input  logic              extint,
  input  logic              pend_clr,
  input  logic              int_ack,
  input  logic [WAKE_W-1:0] wake_dly,
  output pstate_e           state,
  output logic              pd_en,
  output logic              ext_pend
);
  pstate_e state_q, state_d;
  logic    pd_en_q, pd_en_d;
  logic    pend_q, pend_d;
  logic    wake_hit;
  logic    wake_zero;

  assign wake_hit = (state_q == PS_SLEEP) && extint && !rst_req;

  pwrdn_dncount #(.W(WAKE_W)) u_wake_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wake_hit),
    .load_val (wake_dly),
    .dec_en   (state_q == PS_WAKE),
    .zero     (wake_zero)
  );

  always_comb begin
    state_d = state_q;
    if (rst_req) begin
      state_d = PS_RESET;
    end else begin
      unique case (state_q)
        PS_RESET: if (!pll_sel || hold_done) state_d = PS_RUN;
        PS_RUN:   if (pd_req && pd_en_q)     state_d = PS_SLEEP;
        PS_SLEEP: if (extint)                state_d = PS_WAKE;
        PS_WAKE:  if (wake_zero)             state_d = PS_RUN;
        default:                             state_d = PS_RESET;
      endcase
    end
  end

  assign pd_en_d = (state_q == PS_RESET) ? cfg_pd : pd_en_q;

  always_comb begin
    pend_d = pend_q;
    if (rst_req || state_q == PS_RESET)
      pend_d = 1'b0;
    else if (wake_hit)
      pend_d = 1'b1;
    else if (pend_clr || int_ack)
      pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_RESET;
      pd_en_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pd_en_q <= pd_en_d;
      pend_q  <= pend_d;
    end
  end

  assign state    = state_q;
  assign pd_en    = pd_en_q;
  assign ext_pend = pend_q;
endmodule

// File: rtl/pwrdn_ctrl.sv
// Top: reset synchroniser, sequencing and output decode.
module pwrdn_ctrl
  import pwrdn_pkg::*;
#(
  parameter int WAKE_W        = 16,
  parameter int PULLDN_STATES = 16,
  parameter int RST_HOLD_CYC  = 40
) (
  input  logic              clk,
  input  logic              sys_rst_n,
  input  logic              rst_pin_n,
  input  logic              int_rst,
  input  logic              pll_sel,
  input  logic              cfg_pd,
  input  logic              pd_req,
  input  logic              extint,
  input  logic              int_en,
  input  logic              pend_clr,
  input  logic              int_ack,
  input  logic [WAKE_W-1:0] wake_dly,
  output logic              osc_en,
  output logic              pll_en,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic              clkout_hi,
  output logic              bus_idle,
  output logic              ext_pend,
  output logic              int_req,
  output logic              rst_pulldown
);
  logic [1:0] sync_q;
  logic       rst_n_sync;
  logic       rst_req;
  logic       hold_done;
  logic       pd_en;
  pstate_e    state;

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) sync_q <= 2'b00;
    else            sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_n_sync = sync_q[1];

  pwrdn_rst_ctl #(
    .PULLDN_STATES (PULLDN_STATES),
    .RST_HOLD_CYC  (RST_HOLD_CYC)
  ) u_rst_ctl (
    .clk          (clk),
    .rst_n        (rst_n_sync),
    .rst_pin_n    (rst_pin_n),
    .int_rst      (int_rst),
    .in_reset     (state == PS_RESET),
    .rst_req      (rst_req),
    .hold_done    (hold_done),
    .rst_pulldown (rst_pulldown)
  );

  pwrdn_fsm #(.WAKE_W(WAKE_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .rst_req   (rst_req),
    .hold_done (hold_done),
    .pll_sel   (pll_sel),
    .cfg_pd    (cfg_pd),
    .pd_req    (pd_req),
    .extint    (extint),
    .pend_clr  (pend_clr),
    .int_ack   (int_ack),
    .wake_dly  (wake_dly),
    .state     (state),
    .pd_en     (pd_en),
    .ext_pend  (ext_pend)
  );

  always_comb begin
    osc_en     = 1'b1;
    pll_en     = pll_sel;
    cpu_clk_en = 1'b0;
    per_clk_en = 1'b0;
    clkout_hi  = 1'b0;
    bus_idle   = 1'b1;
    unique case (state)
      PS_RUN: begin
        cpu_clk_en = 1'b1;
        per_clk_en = 1'b1;
        bus_idle   = 1'b0;
      end
      PS_SLEEP: begin
        osc_en    = 1'b0;
        pll_en    = 1'b0;
        clkout_hi = 1'b1;
      end
      PS_WAKE:  clkout_hi = 1'b1;
      default: ;
    endcase
  end

  assign int_req = ext_pend && int_en && (state == PS_RUN);
endmodule

// File: rtl/pwrdn_ctrl_chk.sv
// Property checker, attached to the top module by bind.
module pwrdn_ctrl_chk (
  input logic clk,
  input logic rst_n_sync,
  input logic rst_pin_n,
  input logic int_rst,
  input logic pd_req,
  input logic extint,
  input logic int_en,
  input logic pd_en,
  input logic osc_en,
  input logic cpu_clk_en,
  input logic per_clk_en,
  input logic clkout_hi,
  input logic bus_idle,
  input logic ext_pend,
  input logic int_req,
  input logic rst_pulldown
);
  a_r1_enable_frozen_in_run: assert property (@(posedge clk) disable iff (!rst_n_sync)
    cpu_clk_en |=> $stable(pd_en));

  a_r2_disabled_keeps_running: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (cpu_clk_en && !pd_en && pd_req && rst_pin_n && !int_rst) |=> cpu_clk_en);

  a_r3_sleep_outputs: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !osc_en |-> (!cpu_clk_en && !per_clk_en && clkout_hi && bus_idle));

  a_r4_wake_sets_pending: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!osc_en && extint && rst_pin_n && !int_rst) |=> (ext_pend && osc_en));

  a_r5_osc_before_clocks: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $rose(cpu_clk_en) |-> $past(osc_en));

  a_r6_request_needs_flag: assert property (@(posedge clk) disable iff (!rst_n_sync)
    int_req |-> (ext_pend && int_en && cpu_clk_en));

  a_r7_reset_wins: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!rst_pin_n || int_rst) |=> (!ext_pend && !cpu_clk_en && !clkout_hi));

  a_r8_pulldown_on_pin_fall: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $fell(rst_pin_n) |=> rst_pulldown);

  a_r8_pulldown_on_int_rst: assert property (@(posedge clk) disable iff (!rst_n_sync)
    int_rst |=> rst_pulldown);
endmodule

bind pwrdn_ctrl pwrdn_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n_sync   (rst_n_sync),
  .rst_pin_n    (rst_pin_n),
  .int_rst      (int_rst),
  .pd_req       (pd_req),
  .extint       (extint),
  .int_en       (int_en),
  .pd_en        (pd_en),
  .osc_en       (osc_en),
  .cpu_clk_en   (cpu_clk_en),
  .per_clk_en   (per_clk_en),
  .clkout_hi    (clkout_hi),
  .bus_idle     (bus_idle),
  .ext_pend     (ext_pend),
  .int_req      (int_req),
  .rst_pulldown (rst_pulldown)
);

// File: tb/pwrdn_ctrl_tb.sv
module pwrdn_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WAKE_W     = 16;
  localparam int HOLD       = 40;
  localparam int PULSE      = 16;

  logic clk = 1'b0;
  logic sys_rst_n, rst_pin_n, int_rst, pll_sel, cfg_pd, pd_req, extint;
  logic int_en, pend_clr, int_ack;
  logic [WAKE_W-1:0] wake_dly;
  logic osc_en, pll_en, cpu_clk_en, per_clk_en, clkout_hi, bus_idle;
  logic ext_pend, int_req, rst_pulldown;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwrdn_ctrl u_dut (
    .clk (clk), .sys_rst_n (sys_rst_n), .rst_pin_n (rst_pin_n), .int_rst (int_rst),
    .pll_sel (pll_sel), .cfg_pd (cfg_pd), .pd_req (pd_req), .extint (extint),
    .int_en (int_en), .pend_clr (pend_clr), .int_ack (int_ack), .wake_dly (wake_dly),
    .osc_en (osc_en), .pll_en (pll_en), .cpu_clk_en (cpu_clk_en), .per_clk_en (per_clk_en),
    .clkout_hi (clkout_hi), .bus_idle (bus_idle), .ext_pend (ext_pend), .int_req (int_req),
    .rst_pulldown (rst_pulldown)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  // Drive the reset pin low for len cycles; return gated cycle count.
  task automatic pin_reset(input int len, output int gated);
    int i;
    rst_pin_n = 1'b0;
    gated = 0;
    i = 0;
    do begin
      @(negedge clk);
      i++;
      if (i == 1) chk("R8 pulldown after pin fall", rst_pulldown, 1);
      if (i == len) rst_pin_n = 1'b1;
      if (!cpu_clk_en) gated++;
    end while (!cpu_clk_en && i < 2000);
  endtask

  task automatic enter_sleep();
    pd_req = 1'b1;
    @(negedge clk);
    pd_req = 1'b0;
  endtask

  // Wake from sleep with delay d; return gated cycles after the wake edge.
  task automatic wake(input int d, input logic en, output int gated);
    wake_dly = WAKE_W'(d);
    int_en   = en;
    extint   = 1'b1;
    @(negedge clk);
    extint = 1'b0;
    chk("R4 osc on after wake", osc_en, 1);
    chk("R4 pending set regardless of mask", ext_pend, 1);
    gated = 0;
    while (!cpu_clk_en && gated < 1000) begin
      gated++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset_state();
    repeat (3) @(negedge clk);
    chk("R7 reset cpu clk off", cpu_clk_en, 0);
    chk("R7 reset per clk off", per_clk_en, 0);
    chk("R7 reset pending clear", ext_pend, 0);
    chk("R8 no pulldown at start", rst_pulldown, 0);
    sys_rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R10 running after reset", cpu_clk_en, 1);
    chk("R10 bus active", bus_idle, 0);
  endtask

  task automatic t_sleep_and_masked_wake();
    int g;
    enter_sleep();
    chk("R3 osc off", osc_en, 0);
    chk("R3 pll off", pll_en, 0);
    chk("R3 cpu clk off", cpu_clk_en, 0);
    chk("R3 per clk off", per_clk_en, 0);
    chk("R3 clkout high", clkout_hi, 1);
    chk("R3 bus idle", bus_idle, 1);
    repeat (4) @(negedge clk);
    chk("R3 sleep holds", osc_en, 0);
    wake(5, 1'b0, g);
    chk("R5 gated cycles delay 5", g, 6);
    chk("R6 masked no request", int_req, 0);
    repeat (3) @(negedge clk);
    chk("R6 masked flag held", ext_pend, 1);
    pend_clr = 1'b1;
    @(negedge clk);
    pend_clr = 1'b0;
    chk("R6 cleared by software", ext_pend, 0);
  endtask

  task automatic t_unmasked_wake();
    int g;
    enter_sleep();
    wake(0, 1'b1, g);
    chk("R5 gated cycles delay 0", g, 1);
    chk("R6 request raised", int_req, 1);
    int_ack = 1'b1;
    @(negedge clk);
    int_ack = 1'b0;
    chk("R6 ack clears flag", ext_pend, 0);
    chk("R6 ack drops request", int_req, 0);
  endtask

  task automatic t_cfg_latch();
    int g;
    cfg_pd = 1'b0;
    @(negedge clk);
    enter_sleep();
    chk("R1 running change of cfg ignored", osc_en, 0);
    wake(2, 1'b0, g);
    chk("R5 gated cycles delay 2", g, 3);
    pend_clr = 1'b1;
    @(negedge clk);
    pend_clr = 1'b0;
  endtask

  task automatic t_disabled();
    int g;
    pin_reset(3, g);
    chk("R10 pin low 3 cycles", g, 3);
    enter_sleep();
    chk("R2 disabled cpu keeps running", cpu_clk_en, 1);
    @(negedge clk);
    chk("R2 disabled osc stays on", osc_en, 1);
    cfg_pd = 1'b1;
    pin_reset(6, g);
    chk("R10 pin low 6 cycles", g, 6);
  endtask

  task automatic t_reset_priority();
    int g;
    enter_sleep();
    wake_dly = WAKE_W'(3);
    extint = 1'b1;
    rst_pin_n = 1'b0;
    @(negedge clk);
    extint = 1'b0;
    chk("R7 reset beats wake clkout", clkout_hi, 0);
    chk("R7 reset beats wake pending", ext_pend, 0);
    rst_pin_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 back to run", cpu_clk_en, 1);
    enter_sleep();
    wake(1, 1'b0, g);
    chk("R7 pending before reset", ext_pend, 1);
    int_rst = 1'b1;
    @(negedge clk);
    int_rst = 1'b0;
    chk("R7 reset clears pending", ext_pend, 0);
  endtask

  task automatic t_pulldown();
    int n;
    repeat (20) @(negedge clk);
    int_rst = 1'b1;
    @(negedge clk);
    int_rst = 1'b0;
    n = 0;
    while (rst_pulldown && n < 100) begin
      n++;
      @(negedge clk);
    end
    chk("R8 pulldown length", n, PULSE);
  endtask

  task automatic t_pll_hold();
    int g;
    pll_sel = 1'b1;
    @(negedge clk);
    pin_reset(3, g);
    chk("R9 pll hold gated cycles", g, HOLD + 1);
    chk("R9 pll enabled in run", pll_en, 1);
    pll_sel = 1'b0;
  endtask

  initial begin
    sys_rst_n = 1'b0; rst_pin_n = 1'b1; int_rst = 1'b0; pll_sel = 1'b0;
    cfg_pd = 1'b1; pd_req = 1'b0; extint = 1'b0; int_en = 1'b0;
    pend_clr = 1'b0; int_ack = 1'b0; wake_dly = '0;
    t_reset_state();
    t_sleep_and_masked_wake();
    t_unmasked_wake();
    t_cfg_latch();
    t_disabled();
    t_reset_priority();
    t_pulldown();
    t_pll_hold();
    repeat (3) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule